// File: doc/BRIEF.md
# Per-Bit Output Mode General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port for a small 8-bit controller. It holds a data latch and two mode registers, all loaded through a simple write strobe with a register select. For every pin it drives three controls to a pad model: output enable, drive-high and drive-low. It also drives a weak pull-up flag that stands in for the resistive pull-up. Each pin picks one of four output behaviours from one bit of each mode register, so neighbouring pins can behave differently.

Pin levels come back through a synchroniser, so software reads the real pad state. A separate output returns the latch contents for read-modify-write sequences. While the external memory bus is active, the port stops showing latch data and drives the high byte of the bus address instead. While reset is asserted, every pin is driven high at once, without waiting for a clock edge.

Top module: `gpio_mode_port`

## Requirements
- R1: Each pin i takes its mode from the pair {mode1[i], mode2[i]}, independently of every other pin: 00 weak-high bidirectional, 01 push-pull, 10 high impedance, 11 open drain.
- R2: In weak-high bidirectional mode, a latch bit of 0 gives oe=1, drive_lo=1, drive_hi=0. A latch bit of 1 gives oe=0 with only the weak pull-up flag set.
- R3: In push-pull mode, oe=1, drive_hi equals the latch bit and drive_lo is its inverse.
- R4: In high-impedance mode, oe, drive_hi, drive_lo and the pull-up flag are all 0 whatever the latch holds.
- R5: In open-drain mode, a latch bit of 0 gives oe=1 and drive_lo=1. A latch bit of 1 releases the pin (oe=0, no pull-up).
- R6: While rst_n is low, every pin has oe=1, drive_hi=1, drive_lo=0 and pull-up 0. This takes effect immediately, with no clock edge needed.
- R7: After reset the data latch holds all ones and both mode registers hold all zeros, so every pin is released with its pull-up flag set and rd_latch reads 0xFF.
- R8: While xmem_active is high, pin i drives address bit 8+i (xaddr_hi[i]) strongly (oe=1, drive_hi=bit, drive_lo=~bit, pull-up 0), overriding latch and mode. When it drops, the pins return to their mode behaviour.
- R9: A write with wr_en high at a rising clock edge loads wr_data into the latch (wr_sel=0), mode1 (wr_sel=1) or mode2 (wr_sel=2). wr_sel=3 changes nothing.
- R10: rd_pin returns pad_in delayed by exactly two rising clock edges, and rd_latch returns the data latch.
- R11: No pin ever has drive_hi and drive_lo both set, and the pull-up flag is never set on a pin whose oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 latch, 1 mode1, 2 mode2, 3 none |
| wr_data | input | 8 | Write data |
| xmem_active | input | 1 | External memory bus owns the port |
| xaddr_hi | input | 8 | Address bits 15..8 for the bus |
| pad_in | input | 8 | Pad levels seen at the pins |
| pad_oe | output | 8 | Per-pin output enable |
| pad_drv_hi | output | 8 | Per-pin strong drive high |
| pad_drv_lo | output | 8 | Per-pin strong drive low |
| pad_weak_pu | output | 8 | Per-pin weak pull-up flag |
| rd_pin | output | 8 | Synchronised pad levels |
| rd_latch | output | 8 | Data latch contents |

## Verification
The pad controls are pure logic of the registers, so a corrupted latch or mode bit shows on that pin's oe, drive or pull-up outputs at the first sample after the write edge. It also shows at once on rd_latch. A wrong stage count in the pin synchroniser shows as rd_pin changing one edge early or late. A fault in the reset or bus-override paths shows without any clock, because those paths are combinational. Mixed mode patterns with alternating latch bits expose swapped mode bits or bits crossed between pins.

// File: rtl/gpio_mode_pkg.sv
package gpio_mode_pkg;

    // Mode code is {mode1[i], mode2[i]}
    typedef enum logic [1:0] {
        PM_WEAKHI = 2'b00,
        PM_PUSH   = 2'b01,
        PM_HIZ    = 2'b10,
        PM_OPEN   = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        WSEL_LATCH = 2'd0,
        WSEL_MODE1 = 2'd1,
        WSEL_MODE2 = 2'd2,
        WSEL_NONE  = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic oe;
        logic hi;
        logic lo;
        logic pu;
    } pad_ctl_t;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_mode_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] mode1_q,
    output logic [WIDTH-1:0] mode2_q,
    output logic [WIDTH-1:0] pin_sync_q
);

    typedef struct packed {
        logic [WIDTH-1:0]                  lat;
        logic [WIDTH-1:0]                  m1;
        logic [WIDTH-1:0]                  m2;
        logic [SYNC_STAGES-1:0][WIDTH-1:0] sy;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_sel_e'(wr_sel))
                WSEL_LATCH: r_d.lat = wr_data;
                WSEL_MODE1: r_d.m1  = wr_data;
                WSEL_MODE2: r_d.m2  = wr_data;
                default:    ;
            endcase
        end
        r_d.sy[0] = pad_in;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            r_d.sy[s] = r_q.sy[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.lat <= '1;
            r_q.m1  <= '0;
            r_q.m2  <= '0;
            r_q.sy  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign latch_q    = r_q.lat;
    assign mode1_q    = r_q.m1;
    assign mode2_q    = r_q.m2;
    assign pin_sync_q = r_q.sy[SYNC_STAGES-1];

    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (latch_q == $past(wr_data))) // R9
        else $error("latch load");

    AST_NONE_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> ($stable(latch_q) && $stable(mode1_q) && $stable(mode2_q))) // R9
        else $error("select 3 changed state");

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_mode_pkg::*;
(
    input  logic     rst_n,
    input  logic     xmem_active,
    input  logic     addr_bit,
    input  logic     lat,
    input  logic     m1,
    input  logic     m2,
    output pad_ctl_t ctl
);

    always_comb begin
        ctl = '0;
        if (!rst_n) begin
            ctl.oe = 1'b1;
            ctl.hi = 1'b1;
        end else if (xmem_active) begin
            ctl.oe = 1'b1;
            ctl.hi = addr_bit;
            ctl.lo = ~addr_bit;
        end else begin
            case (pin_mode_e'({m1, m2}))
                PM_WEAKHI: begin
                    ctl.oe = ~lat;
                    ctl.lo = ~lat;
                    ctl.pu = lat;
                end
                PM_PUSH: begin
                    ctl.oe = 1'b1;
                    ctl.hi = lat;
                    ctl.lo = ~lat;
                end
                PM_OPEN: begin
                    ctl.oe = ~lat;
                    ctl.lo = ~lat;
                end
                default: ctl = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
    import gpio_mode_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             xmem_active,
    input  logic [WIDTH-1:0] xaddr_hi,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_drv_hi,
    output logic [WIDTH-1:0] pad_drv_lo,
    output logic [WIDTH-1:0] pad_weak_pu,
    output logic [WIDTH-1:0] rd_pin,
    output logic [WIDTH-1:0] rd_latch
);

    logic [WIDTH-1:0] latch_q, mode1_q, mode2_q;

    gpio_port_regs #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .pad_in     (pad_in),
        .latch_q    (latch_q),
        .mode1_q    (mode1_q),
        .mode2_q    (mode2_q),
        .pin_sync_q (rd_pin)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        pad_ctl_t ctl;
        gpio_pin_drive u_drv (
            .rst_n       (rst_n),
            .xmem_active (xmem_active),
            .addr_bit    (xaddr_hi[i]),
            .lat         (latch_q[i]),
            .m1          (mode1_q[i]),
            .m2          (mode2_q[i]),
            .ctl         (ctl)
        );
        assign pad_oe[i]      = ctl.oe;
        assign pad_drv_hi[i]  = ctl.hi;
        assign pad_drv_lo[i]  = ctl.lo;
        assign pad_weak_pu[i] = ctl.pu;
    end

    assign rd_latch = latch_q;

    AST_RESET_DRIVE_HIGH: assert property (@(negedge clk)
        !rst_n |-> (pad_oe == '1 && pad_drv_hi == '1 && pad_drv_lo == '0 && pad_weak_pu == '0)) // R6
        else $error("reset drive");

    AST_XMEM_ADDR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        xmem_active |-> (pad_oe == '1 && pad_drv_hi == xaddr_hi && pad_weak_pu == '0)) // R8
        else $error("address override");

    AST_HIZ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !xmem_active |-> ((pad_oe & mode1_q & ~mode2_q) == '0)) // R4
        else $error("high-z pin enabled");

    AST_NO_DRIVE_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_drv_hi & pad_drv_lo) == '0) && ((pad_weak_pu & pad_oe) == '0)) // R11
        else $error("drive conflict");

endmodule

// File: tb/gpio_mode_port_test.sv
module gpio_mode_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       xmem_active = 1'b0;
    logic [7:0] xaddr_hi = 8'h00;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_oe, pad_drv_hi, pad_drv_lo, pad_weak_pu, rd_pin, rd_latch;

    int total = 0;
    int fails = 0;
    logic [7:0] m_lat = 8'hFF, m_m1 = 8'h00, m_m2 = 8'h00;

    always #5 clk = ~clk;

    gpio_mode_port uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .xmem_active(xmem_active), .xaddr_hi(xaddr_hi), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_drv_hi(pad_drv_hi), .pad_drv_lo(pad_drv_lo),
        .pad_weak_pu(pad_weak_pu), .rd_pin(rd_pin), .rd_latch(rd_latch)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // {oe,hi,lo,pu} from the requirement text
    function automatic logic [3:0] exp_bit(input logic xm, input logic a, input logic m1,
                                           input logic m2, input logic l);
        if (xm) return {1'b1, a, ~a, 1'b0};
        case ({m1, m2})
            2'b00:   return l ? 4'b0001 : 4'b1010;
            2'b01:   return l ? 4'b1100 : 4'b1010;
            2'b10:   return 4'b0000;
            default: return l ? 4'b0000 : 4'b1010;
        endcase
    endfunction

    task automatic check_pins(input string tag);
        logic [7:0] e_oe, e_hi, e_lo, e_pu;
        for (int i = 0; i < 8; i++) begin
            logic [3:0] e;
            e = exp_bit(xmem_active, xaddr_hi[i], m_m1[i], m_m2[i], m_lat[i]);
            {e_oe[i], e_hi[i], e_lo[i], e_pu[i]} = e;
        end
        chk(tag, "oe", pad_oe, e_oe);
        chk(tag, "drv_hi", pad_drv_hi, e_hi);
        chk(tag, "drv_lo", pad_drv_lo, e_lo);
        chk(tag, "weak_pu", pad_weak_pu, e_pu);
        chk("R11", "hi&lo", pad_drv_hi & pad_drv_lo, 8'h00);
        chk("R11", "pu&oe", pad_weak_pu & pad_oe, 8'h00);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            2'd0: m_lat = d;
            2'd1: m_m1 = d;
            2'd2: m_m2 = d;
            default: ;
        endcase
    endtask

    task automatic t_reset;
        #12;
        chk("R6", "oe in reset", pad_oe, 8'hFF);
        chk("R6", "hi in reset", pad_drv_hi, 8'hFF);
        chk("R6", "lo in reset", pad_drv_lo, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R7", "latch after reset", rd_latch, 8'hFF);
        chk("R7", "pull-up after reset", pad_weak_pu, 8'hFF);
        check_pins("R7");
    endtask

    task automatic t_modes;
        wr(2'd0, 8'hA5);
        chk("R9", "latch write", rd_latch, 8'hA5);
        check_pins("R2");
        wr(2'd2, 8'hFF);
        check_pins("R3");
        wr(2'd1, 8'hFF); wr(2'd2, 8'h00);
        check_pins("R4");
        wr(2'd2, 8'hFF);
        check_pins("R5");
        wr(2'd0, 8'h5A);
        check_pins("R5");
        wr(2'd1, 8'b1100_1100); wr(2'd2, 8'b1010_1010); wr(2'd0, 8'h0F);
        check_pins("R1");
        wr(2'd0, 8'hF0);
        check_pins("R1");
    endtask

    task automatic t_ignore_sel;
        wr(2'd3, 8'h00);
        chk("R9", "sel3 latch", rd_latch, 8'hF0);
        check_pins("R9");
    endtask

    task automatic t_xmem;
        @(negedge clk); xmem_active = 1'b1; xaddr_hi = 8'h3C;
        #1;
        chk("R8", "addr on hi", pad_drv_hi, 8'h3C);
        check_pins("R8");
        @(negedge clk); xaddr_hi = 8'hC1;
        #1;
        check_pins("R8");
        @(negedge clk); xmem_active = 1'b0;
        #1;
        check_pins("R8");
    endtask

    task automatic t_read;
        @(negedge clk); pad_in = 8'h5A;
        @(negedge clk);
        chk("R10", "rd_pin after 1 edge", rd_pin, 8'h00);
        @(negedge clk);
        chk("R10", "rd_pin after 2 edges", rd_pin, 8'h5A);
        chk("R10", "rd_latch", rd_latch, m_lat);
    endtask

    task automatic t_async_reset;
        wr(2'd1, 8'h00); wr(2'd2, 8'hFF); wr(2'd0, 8'h00);
        check_pins("R3");
        @(negedge clk); #2 rst_n = 1'b0;
        #1;
        chk("R6", "async oe", pad_oe, 8'hFF);
        chk("R6", "async hi", pad_drv_hi, 8'hFF);
        chk("R6", "async lo", pad_drv_lo, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        m_lat = 8'hFF; m_m1 = 8'h00; m_m2 = 8'h00;
        #1;
        chk("R7", "latch re-reset", rd_latch, 8'hFF);
        check_pins("R7");
    endtask

    initial begin
        t_reset();
        t_modes();
        t_ignore_sel();
        t_xmem();
        t_read();
        t_async_reset();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #200000;
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule